// File: doc/BRIEF.md
# Pipelined DES Cipher Core

This block is a fully unrolled DES engine that takes one 64-bit data block, one 64-bit key and one direction bit on every clock cycle. It returns the matching 64-bit result a fixed number of cycles later. Nothing stalls and nothing needs to be flushed. A stream of blocks can change key and direction from one cycle to the next, and each result comes out in issue order.

Inside, each of the sixteen rounds is one register stage. The right half of the state is held in its 48-bit expanded form, so the subkey is mixed in that domain. The expansion of the new right half is formed as the XOR of the expansions of the old left half and the round-function output, which folds one round's right-side XOR into the next round's key mix. A left-inverse of the expansion (a reduction) gives back the 32-bit half where the next left half needs it. This restructuring needs one extra stage before round one, which prepares the first key mix. Every stage carries its own copy of the permuted key and of the direction bit, and it derives its subkey from them. Two input and two output register stages isolate the core from its surroundings. The total latency is 21 cycles.

Bit numbering follows the cipher's convention. DES bit 1 is bit 63 of `in_block`, `in_key` and `out_block`.

Top module: `des_pipe_core`

## Requirements
- R1: With `in_decrypt` = 0, `out_block` equals the standard DES encryption of `in_block` under `in_key`.
- R2: With `in_decrypt` = 1, `out_block` equals the standard DES decryption of `in_block` under `in_key`, applying the subkeys in reverse order.
- R3: Key bits `in_key[0]`, `in_key[8]`, ..., `in_key[56]` (the least significant bit of each byte) are parity bits and have no effect on the result.
- R4: A block captured at a rising edge with `in_valid` = 1 appears on `out_block` with `out_valid` = 1 right after the 21st rising edge, counting the capture edge as the first.
- R5: Blocks may be issued on consecutive cycles, each with its own key and direction. Every one of them yields its own correct result, in issue order, with no dead cycles.
- R6: A cycle with `in_valid` = 0 yields a cycle with `out_valid` = 0 exactly 21 cycles later, and no result is produced for it.
- R7: While `rst_n` is low, and afterwards until the first valid block has travelled through, `out_valid` is 0.
- R8: Two identical consecutive inputs (same block, key and direction) produce identical consecutive results, so no state leaks between blocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | The inputs in this cycle form a block to process |
| in_decrypt | input | 1 | 0 = encrypt, 1 = decrypt |
| in_key | input | 64 | Key including byte parity bits |
| in_block | input | 64 | Plaintext or ciphertext block |
| out_valid | output | 1 | `out_block` holds a result this cycle |
| out_block | output | 64 | Result block |

## Verification
Every result is due exactly 21 rising edges after its capture edge, and each empty input cycle produces an empty output cycle the same distance later. The scoreboard driver stamps every expected item with the cycle count at issue. The monitor samples on the falling edge and checks both the value and that the cycle count has advanced by exactly 21. A valid output with nothing outstanding counts as a failure. Known-answer vectors are run in both directions, back to back with alternating keys. Pairs that differ only in parity bits, and pairs that are exact repeats, are also checked against the expected result; in the bound checker they are checked against the result of the previous cycle.

// File: rtl/des_pipe_pkg.sv
package des_pipe_pkg;

    localparam int BLK_W     = 64;
    localparam int KEY_W     = 64;
    localparam int HALF_W    = BLK_W / 2;
    localparam int EXP_W     = HALF_W + HALF_W / 2;
    localparam int CD_W      = 56;
    localparam int CD_HALF   = CD_W / 2;
    localparam int ROUNDS    = 16;
    localparam int SBOX_N    = 8;
    localparam int IN_STAGES = 2;
    localparam int PREP_STAGES = 1;
    localparam int OUT_STAGES  = 2;
    localparam int LATENCY   = IN_STAGES + PREP_STAGES + ROUNDS + OUT_STAGES;
    localparam logic [KEY_W-1:0] KEY_PARITY_MASK = 64'h0101_0101_0101_0101;

    typedef struct packed {
        logic              vld;
        logic              dec;
        logic [CD_W-1:0]   cd;
        logic [HALF_W-1:0] lh;
        logic [EXP_W-1:0]  rx;
        logic [EXP_W-1:0]  kx;
    } stage_t;

    localparam int IP_T [64] = '{
        58,50,42,34,26,18,10,2, 60,52,44,36,28,20,12,4,
        62,54,46,38,30,22,14,6, 64,56,48,40,32,24,16,8,
        57,49,41,33,25,17,9,1,  59,51,43,35,27,19,11,3,
        61,53,45,37,29,21,13,5, 63,55,47,39,31,23,15,7};

    localparam int P_T [32] = '{
        16,7,20,21,29,12,28,17, 1,15,23,26,5,18,31,10,
        2,8,24,14,32,27,3,9,    19,13,30,6,22,11,4,25};

    localparam int PC1_T [56] = '{
        57,49,41,33,25,17,9,1,58,50,42,34,26,18,
        10,2,59,51,43,35,27,19,11,3,60,52,44,36,
        63,55,47,39,31,23,15,7,62,54,46,38,30,22,
        14,6,61,53,45,37,29,21,13,5,28,20,12,4};

    localparam int PC2_T [48] = '{
        14,17,11,24,1,5,3,28,15,6,21,10,
        23,19,12,4,26,8,16,7,27,20,13,2,
        41,52,31,37,47,55,30,40,51,45,33,48,
        44,49,39,56,34,53,46,42,50,36,29,32};

    localparam logic [3:0] SB1 [64] = '{
        14,4,13,1,2,15,11,8,3,10,6,12,5,9,0,7,
        0,15,7,4,14,2,13,1,10,6,12,11,9,5,3,8,
        4,1,14,8,13,6,2,11,15,12,9,7,3,10,5,0,
        15,12,8,2,4,9,1,7,5,11,3,14,10,0,6,13};
    localparam logic [3:0] SB2 [64] = '{
        15,1,8,14,6,11,3,4,9,7,2,13,12,0,5,10,
        3,13,4,7,15,2,8,14,12,0,1,10,6,9,11,5,
        0,14,7,11,10,4,13,1,5,8,12,6,9,3,2,15,
        13,8,10,1,3,15,4,2,11,6,7,12,0,5,14,9};
    localparam logic [3:0] SB3 [64] = '{
        10,0,9,14,6,3,15,5,1,13,12,7,11,4,2,8,
        13,7,0,9,3,4,6,10,2,8,5,14,12,11,15,1,
        13,6,4,9,8,15,3,0,11,1,2,12,5,10,14,7,
        1,10,13,0,6,9,8,7,4,15,14,3,11,5,2,12};
    localparam logic [3:0] SB4 [64] = '{
        7,13,14,3,0,6,9,10,1,2,8,5,11,12,4,15,
        13,8,11,5,6,15,0,3,4,7,2,12,1,10,14,9,
        10,6,9,0,12,11,7,13,15,1,3,14,5,2,8,4,
        3,15,0,6,10,1,13,8,9,4,5,11,12,7,2,14};
    localparam logic [3:0] SB5 [64] = '{
        2,12,4,1,7,10,11,6,8,5,3,15,13,0,14,9,
        14,11,2,12,4,7,13,1,5,0,15,10,3,9,8,6,
        4,2,1,11,10,13,7,8,15,9,12,5,6,3,0,14,
        11,8,12,7,1,14,2,13,6,15,0,9,10,4,5,3};
    localparam logic [3:0] SB6 [64] = '{
        12,1,10,15,9,2,6,8,0,13,3,4,14,7,5,11,
        10,15,4,2,7,12,9,5,6,1,13,14,0,11,3,8,
        9,14,15,5,2,8,12,3,7,0,4,10,1,13,11,6,
        4,3,2,12,9,5,15,10,11,14,1,7,6,0,8,13};
    localparam logic [3:0] SB7 [64] = '{
        4,11,2,14,15,0,8,13,3,12,9,7,5,10,6,1,
        13,0,11,7,4,9,1,10,14,3,5,12,2,15,8,6,
        1,4,11,13,12,3,7,14,10,15,6,8,0,5,9,2,
        6,11,13,8,1,4,10,7,9,5,0,15,14,2,3,12};
    localparam logic [3:0] SB8 [64] = '{
        13,2,8,4,6,15,11,1,10,9,3,14,5,0,12,7,
        1,15,13,8,10,3,7,4,12,5,6,11,0,14,9,2,
        7,11,4,1,9,12,14,2,0,6,10,13,15,3,5,8,
        2,1,14,7,4,10,8,13,15,12,9,0,3,5,6,11};

    // Tables use 1-based numbering with bit 1 as the most significant bit.
    function automatic logic [BLK_W-1:0] perm_ip(input logic [BLK_W-1:0] x);
        logic [BLK_W-1:0] y;
        for (int k = 0; k < BLK_W; k++) y[BLK_W-1-k] = x[BLK_W-IP_T[k]];
        return y;
    endfunction

    // Final permutation obtained by inverting the initial one.
    function automatic logic [BLK_W-1:0] perm_fp(input logic [BLK_W-1:0] x);
        logic [BLK_W-1:0] y;
        for (int k = 0; k < BLK_W; k++) y[BLK_W-IP_T[k]] = x[BLK_W-1-k];
        return y;
    endfunction

    // Expansion: group g of six takes input bits 4g-1 .. 4g+4 (wrapping).
    function automatic logic [EXP_W-1:0] expand(input logic [HALF_W-1:0] x);
        logic [EXP_W-1:0] y;
        for (int g = 0; g < SBOX_N; g++)
            for (int j = 0; j < 6; j++)
                y[EXP_W-1-(6*g+j)] = x[HALF_W-1-((4*g+j+HALF_W-1) % HALF_W)];
        return y;
    endfunction

    // Left inverse of expand: each half bit is taken from an interior copy.
    function automatic logic [HALF_W-1:0] reduce(input logic [EXP_W-1:0] x);
        logic [HALF_W-1:0] y;
        for (int i = 0; i < HALF_W; i++)
            y[HALF_W-1-i] = x[EXP_W-1-(6*(i/4) + (i%4) + 1)];
        return y;
    endfunction

    function automatic logic [HALF_W-1:0] perm_p(input logic [HALF_W-1:0] x);
        logic [HALF_W-1:0] y;
        for (int k = 0; k < HALF_W; k++) y[HALF_W-1-k] = x[HALF_W-P_T[k]];
        return y;
    endfunction

    function automatic logic [CD_W-1:0] perm_pc1(input logic [KEY_W-1:0] x);
        logic [CD_W-1:0] y;
        for (int k = 0; k < CD_W; k++) y[CD_W-1-k] = x[KEY_W-PC1_T[k]];
        return y;
    endfunction

    function automatic logic [EXP_W-1:0] perm_pc2(input logic [CD_W-1:0] x);
        logic [EXP_W-1:0] y;
        for (int k = 0; k < EXP_W; k++) y[EXP_W-1-k] = x[CD_W-PC2_T[k]];
        return y;
    endfunction

    // Total left rotation of each key half before round idx (1-based).
    function automatic int key_shift_total(input int idx);
        int n;
        n = 0;
        for (int r = 0; r < idx; r++)
            n += (r == 0 || r == 1 || r == 8 || r == ROUNDS-1) ? 1 : 2;
        return n % CD_HALF;
    endfunction

    function automatic logic [CD_HALF-1:0] rotl_half(input logic [CD_HALF-1:0] x, input int n);
        logic [CD_HALF-1:0] y;
        for (int k = 0; k < CD_HALF; k++) y[(k + n) % CD_HALF] = x[k];
        return y;
    endfunction

    function automatic logic [EXP_W-1:0] round_key(input logic [CD_W-1:0] cd, input int idx);
        int n;
        n = key_shift_total(idx);
        return perm_pc2({rotl_half(cd[CD_W-1:CD_HALF], n), rotl_half(cd[CD_HALF-1:0], n)});
    endfunction

    function automatic logic [3:0] sbox_nib(input int b, input logic [5:0] six);
        logic [5:0] idx;
        idx = {six[5], six[0], six[4:1]};
        case (b)
            0: return SB1[idx];
            1: return SB2[idx];
            2: return SB3[idx];
            3: return SB4[idx];
            4: return SB5[idx];
            5: return SB6[idx];
            6: return SB7[idx];
            default: return SB8[idx];
        endcase
    endfunction

    function automatic logic [HALF_W-1:0] feistel_f(input logic [EXP_W-1:0] kx);
        logic [HALF_W-1:0] s;
        for (int b = 0; b < SBOX_N; b++)
            s[HALF_W-1-4*b -: 4] = sbox_nib(b, kx[EXP_W-1-6*b -: 6]);
        return perm_p(s);
    endfunction

endpackage

// File: rtl/des_subkey_sel.sv
module des_subkey_sel
    import des_pipe_pkg::*;
#(
    parameter int ROUND = 1
) (
    input  logic [CD_W-1:0]  cd,
    input  logic             dec,
    output logic [EXP_W-1:0] subkey
);
    localparam int ENC_IDX = ROUND;
    localparam int DEC_IDX = ROUNDS + 1 - ROUND;

    logic [EXP_W-1:0] k_enc;
    logic [EXP_W-1:0] k_dec;

    always_comb begin
        k_enc  = round_key(cd, ENC_IDX);
        k_dec  = round_key(cd, DEC_IDX);
        subkey = dec ? k_dec : k_enc;
    end
endmodule

// File: rtl/des_round_stage.sv
module des_round_stage
    import des_pipe_pkg::*;
#(
    parameter int ROUND = 1,
    parameter bit LAST  = 1'b0
) (
    input  logic   clk,
    input  logic   rst_n,
    input  stage_t s_in,
    output stage_t s_q
);
    logic [HALF_W-1:0] f_out;
    logic [EXP_W-1:0]  rx_next;
    logic [EXP_W-1:0]  kx_next;
    stage_t            s_d;

    // S-boxes read the registered key mix; new expanded right half is
    // formed in the expanded domain from the old left half and f.
    always_comb begin
        f_out   = feistel_f(s_in.kx);
        rx_next = expand(s_in.lh) ^ expand(f_out);
    end

    generate
        if (LAST) begin : g_tail
            assign kx_next = '0;
        end else begin : g_mid
            logic [EXP_W-1:0] k_next;
            des_subkey_sel #(.ROUND(ROUND + 1)) u_ks (
                .cd     (s_in.cd),
                .dec    (s_in.dec),
                .subkey (k_next)
            );
            assign kx_next = rx_next ^ k_next;
        end
    endgenerate

    always_comb begin
        s_d     = s_in;
        s_d.lh  = reduce(s_in.rx);
        s_d.rx  = rx_next;
        s_d.kx  = kx_next;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/des_pipe_core.sv
module des_pipe_core
    import des_pipe_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_decrypt,
    input  logic [KEY_W-1:0] in_key,
    input  logic [BLK_W-1:0] in_block,
    output logic             out_valid,
    output logic [BLK_W-1:0] out_block
);
    // Input stage A: raw capture.
    logic             cap_vld;
    logic             cap_dec;
    logic [KEY_W-1:0] cap_key;
    logic [BLK_W-1:0] cap_blk;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_vld <= 1'b0;
            cap_dec <= 1'b0;
            cap_key <= '0;
            cap_blk <= '0;
        end else begin
            cap_vld <= in_valid;
            cap_dec <= in_decrypt;
            cap_key <= in_key;
            cap_blk <= in_block;
        end
    end

    // Input stage B: permutations (pure wiring) and expansion of R0.
    stage_t           ent_d, ent_q;
    logic [BLK_W-1:0] ip_blk;

    always_comb begin
        ip_blk    = perm_ip(cap_blk);
        ent_d.vld = cap_vld;
        ent_d.dec = cap_dec;
        ent_d.cd  = perm_pc1(cap_key);
        ent_d.lh  = ip_blk[BLK_W-1:HALF_W];
        ent_d.rx  = expand(ip_blk[HALF_W-1:0]);
        ent_d.kx  = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ent_q <= '0;
        else        ent_q <= ent_d;
    end

    // Extra first-round stage: registers the first key mix.
    stage_t           chain [0:ROUNDS];
    stage_t           prep_d;
    logic [EXP_W-1:0] k_first;
    logic             unused_ent_kx;

    des_subkey_sel #(.ROUND(1)) u_ks_first (
        .cd     (ent_q.cd),
        .dec    (ent_q.dec),
        .subkey (k_first)
    );

    assign unused_ent_kx = ^ent_q.kx;

    always_comb begin
        prep_d    = ent_q;
        prep_d.kx = ent_q.rx ^ k_first;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[0] <= '0;
        else        chain[0] <= prep_d;
    end

    // Sixteen round stages.
    generate
        for (genvar g = 1; g <= ROUNDS; g++) begin : g_round
            des_round_stage #(
                .ROUND (g),
                .LAST  (g == ROUNDS)
            ) u_round (
                .clk   (clk),
                .rst_n (rst_n),
                .s_in  (chain[g-1]),
                .s_q   (chain[g])
            );
        end
    endgenerate

    // Output stages: swap halves, final permutation, then retime.
    logic                  unused_tail;
    logic [OUT_STAGES-1:0] ov;
    logic [BLK_W-1:0]      ob [OUT_STAGES];

    assign unused_tail = ^{chain[ROUNDS].dec, chain[ROUNDS].cd, chain[ROUNDS].kx};

    generate
        for (genvar o = 0; o < OUT_STAGES; o++) begin : g_out
            if (o == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) begin
                        ov[0] <= 1'b0;
                        ob[0] <= '0;
                    end else begin
                        ov[0] <= chain[ROUNDS].vld;
                        ob[0] <= perm_fp({reduce(chain[ROUNDS].rx), chain[ROUNDS].lh});
                    end
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) begin
                        ov[o] <= 1'b0;
                        ob[o] <= '0;
                    end else begin
                        ov[o] <= ov[o-1];
                        ob[o] <= ob[o-1];
                    end
                end
            end
        end
    endgenerate

    assign out_valid = ov[OUT_STAGES-1];
    assign out_block = ob[OUT_STAGES-1];
endmodule

// File: rtl/des_pipe_core_chk.sv
module des_pipe_core_chk
    import des_pipe_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_decrypt,
    input logic [KEY_W-1:0] in_key,
    input logic [BLK_W-1:0] in_block,
    input logic             out_valid,
    input logic [BLK_W-1:0] out_block
);
    logic               prev_v;
    logic               prev_dec;
    logic [KEY_W-1:0]   prev_key;
    logic [BLK_W-1:0]   prev_blk;
    logic [LATENCY-1:0] v_line;
    logic [LATENCY-1:0] same_line;
    logic [LATENCY-1:0] par_line;
    logic               par_now;
    logic               same_now;

    always_comb begin
        par_now  = in_valid && prev_v && (in_decrypt == prev_dec) &&
                   (in_block == prev_blk) &&
                   (((in_key ^ prev_key) & ~KEY_PARITY_MASK) == '0);
        same_now = par_now && (in_key == prev_key);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_v    <= 1'b0;
            prev_dec  <= 1'b0;
            prev_key  <= '0;
            prev_blk  <= '0;
            v_line    <= '0;
            same_line <= '0;
            par_line  <= '0;
        end else begin
            prev_v    <= in_valid;
            prev_dec  <= in_decrypt;
            prev_key  <= in_key;
            prev_blk  <= in_block;
            v_line    <= {v_line[LATENCY-2:0], in_valid};
            same_line <= {same_line[LATENCY-2:0], same_now};
            par_line  <= {par_line[LATENCY-2:0], par_now};
        end
    end

    p_result_due_r4: assert property (@(posedge clk) disable iff (!rst_n)
        v_line[LATENCY-1] |-> out_valid);

    p_bubble_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !v_line[LATENCY-1] |-> !out_valid);

    p_valid_known_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$isunknown(out_valid));

    p_repeat_match_r8: assert property (@(posedge clk) disable iff (!rst_n)
        same_line[LATENCY-1] |-> (out_block == $past(out_block)));

    p_parity_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
        par_line[LATENCY-1] |-> (out_block == $past(out_block)));
endmodule

bind des_pipe_core des_pipe_core_chk u_chk (.*);

// File: tb/des_pipe_core_tb_top.sv
`timescale 1ns/1ps
module des_pipe_core_tb_top;
    localparam int LAT = 21;
    localparam logic [63:0] PMASK = 64'h0101_0101_0101_0101;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_decrypt = 1'b0;
    logic [63:0] in_key = '0;
    logic [63:0] in_block = '0;
    logic        out_valid;
    logic [63:0] out_block;

    always #2 clk = ~clk;

    des_pipe_core dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_decrypt (in_decrypt),
        .in_key     (in_key),
        .in_block   (in_block),
        .out_valid  (out_valid),
        .out_block  (out_block)
    );

    typedef struct {
        logic [63:0] exp;
        int          issue;
        string       tag;
    } exp_t;

    exp_t sb_q[$];
    exp_t mon_item;
    int   cyc = 0;
    int   tests = 0;
    int   fails = 0;

    logic [63:0] vk [5] = '{64'h1334_5779_9BBC_DFF1, 64'h0E32_9232_EA6D_0D73,
                             64'h0000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF,
                             64'h0123_4567_89AB_CDEF};
    logic [63:0] vp [5] = '{64'h0123_4567_89AB_CDEF, 64'h8787_8787_8787_8787,
                             64'h0000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF,
                             64'h4E6F_7720_6973_2074};
    logic [63:0] vc [5] = '{64'h85E8_1354_0F0A_B405, 64'h0000_0000_0000_0000,
                             64'h8CA6_4DE9_C1B1_23A7, 64'h7359_B216_3E4E_DC58,
                             64'h3FA4_0E8A_984D_4815};

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag,
                         input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic send(input logic [63:0] k, input logic [63:0] b, input logic dec,
                        input logic [63:0] e, input string tag);
        exp_t it;
        @(negedge clk);
        in_valid   = 1'b1;
        in_key     = k;
        in_block   = b;
        in_decrypt = dec;
        it.exp = e;
        it.issue = cyc;
        it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            in_valid   = 1'b0;
            in_key     = 64'hA5A5_5A5A_0F0F_F0F0;
            in_block   = 64'hDEAD_BEEF_CAFE_F00D;
            in_decrypt = 1'b1;
        end
    endtask

    // Monitor: value and cycle of each result against the scoreboard.
    always @(negedge clk) begin
        if (rst_n && out_valid === 1'b1) begin
            if (sb_q.size() == 0) begin
                check(1'b0, "R6 result without an issued block", out_block, '0);
            end else begin
                mon_item = sb_q.pop_front();
                check(out_block === mon_item.exp, mon_item.tag, out_block, mon_item.exp);
                check((cyc - mon_item.issue) == LAT, "R4 latency",
                      64'(cyc - mon_item.issue), 64'(LAT));
            end
        end
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin : stim
        // R7: quiet output during and after reset.
        repeat (3) begin
            @(negedge clk);
            check(out_valid === 1'b0, "R7 valid low in reset", 64'(out_valid), '0);
        end
        @(negedge clk);
        rst_n = 1'b1;
        repeat (4) begin
            idle(1);
            check(out_valid === 1'b0, "R7 valid low after reset", 64'(out_valid), '0);
        end

        // R1: encryption known answers, back to back.
        for (int i = 0; i < 5; i++) send(vk[i], vp[i], 1'b0, vc[i], "R1 encrypt");
        // R2: decryption known answers.
        for (int i = 0; i < 5; i++) send(vk[i], vc[i], 1'b1, vp[i], "R2 decrypt");
        // R3: parity bits flipped, adjacent to the unflipped twin.
        send(vk[0], vp[0], 1'b0, vc[0], "R3 parity reference");
        send(vk[0] ^ PMASK, vp[0], 1'b0, vc[0], "R3 parity flipped encrypt");
        send(vk[4] ^ PMASK, vc[4], 1'b1, vp[4], "R3 parity flipped decrypt");
        // R6: bubbles between blocks.
        send(vk[2], vp[2], 1'b0, vc[2], "R6 before gap");
        idle(3);
        send(vk[3], vc[3], 1'b1, vp[3], "R6 after gap");
        idle(2);
        // R5: every-cycle burst alternating key and direction.
        for (int i = 0; i < 10; i++) begin
            if (i % 2 == 1) send(vk[i % 5], vc[i % 5], 1'b1, vp[i % 5], "R5 burst decrypt");
            else            send(vk[i % 5], vp[i % 5], 1'b0, vc[i % 5], "R5 burst encrypt");
        end
        // R8: identical consecutive blocks.
        send(vk[1], vp[1], 1'b0, vc[1], "R8 first copy");
        send(vk[1], vp[1], 1'b0, vc[1], "R8 second copy");
        idle(LAT + 6);
        check(sb_q.size() == 0, "R4 all results returned", 64'(sb_q.size()), '0);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule